// File: doc/BRIEF.md
# Memory Type Range Resolver

This block sits beside a translation cache and works out the caching type of a 4 KiB page at the moment a translation is loaded. It holds a small bank of variable physical-address ranges, each with a base, a mask, a valid flag and a memory type, plus a control register with a global enable and a fallback type. When the fill logic presents a physical page frame number together with the attribute type taken from the page-table entry, the block finds the matching ranges and settles any overlap among them. It then merges that range type with the page type and returns one effective type one cycle later. The fill logic stores that type in the new translation entry, so accesses that hit the entry need no range lookup.

Software updates the ranges through a simple register-write port. Each accepted write raises a one-cycle flush request. The translation cache must answer it by dropping every entry, global ones included, because any stored type may now be out of date.

Top module: `mem_type_resolver`

## Requirements
- R1: After reset `rspValid` and `flushReq` are 0, the global enable is cleared, the fallback type is UC and every range is invalid, so every lookup resolves to UC.
- R2: Types are 3-bit codes: 0 = UC, 1 = WC, 4 = WT, 5 = WP, 6 = WB; any other code (2, 3, 7), whether in a range, the fallback or the page type, is treated as UC, and `rspType` only ever carries one of the five legal codes.
- R3: Register map on `cfgAddr`: address 0 is control (`cfgWrData[2:0]` fallback type, bit 3 global enable); for range i, address 2+2i is its base (`cfgWrData[PFN_W+2:3]` base frame number, bits 2:0 type) and address 3+2i is its mask (`cfgWrData[PFN_W+2:3]` mask, bit 0 valid); address 1 and addresses from 2+2*NUM_RANGES upward are unmapped.
- R4: A range matches a lookup when it is valid and (lkPfn & mask) == (base & mask), compared on 4 KiB frame numbers; an invalid range never matches.
- R5: Among matching ranges, any UC (or reserved) type gives UC; if all matching ranges have the same type, that type is used; a mix of only WT and WB gives WT; any other mix gives UC.
- R6: When the global enable is set and no range matches, the fallback type is used; when the enable is cleared, the range result is UC for every address.
- R7: Merging the range result with the page type: UC on either side gives UC; otherwise WC on either side gives WC; otherwise WT on either side gives WT; otherwise WP on either side gives WP; otherwise WB.
- R8: A lookup with `lkReq` high at a clock edge produces `rspValid` high with the effective `rspType` for that request at the next edge, and `rspValid` is low when there was no request.
- R9: A write to any mapped address makes `flushReq` high for exactly the cycle after the write; a write to an unmapped address changes no state and raises no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | ADDR_W | Register address |
| cfgWrData | input | PFN_W+3 | Register write data |
| lkReq | input | 1 | Lookup request from the translation fill |
| lkPfn | input | PFN_W | Physical 4 KiB frame number to resolve |
| lkPageType | input | 3 | Attribute type from the page-table entry |
| rspValid | output | 1 | Effective type is valid |
| rspType | output | 3 | Effective memory type |
| flushReq | output | 1 | Request to invalidate all translation entries |

## Verification
The assertions assume that `lkPageType` and `cfgAddr` are known whenever their strobes are high, and that a lookup and a write in the same cycle may see the old register contents. The checks on the merge rule also depend on the page type alone, so they hold whatever the range bank holds. The stimulus drives every input to a defined value from reset onward. It changes them only on the falling clock edge and never overlaps a write with a lookup. Each lookup therefore meets the register state of the most recent completed write.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctlWe;    // control register write
    logic rangeWe;  // range register write
    logic maskSel;  // 1: mask half, 0: base half
    logic flush;    // accepted write, flush needed
  } mtrStrb_t;

  // Reserved codes fold to UC
  function automatic logic [2:0] normType(input logic [2:0] t);
    case (t)
      MT_WC, MT_WT, MT_WP, MT_WB: normType = t;
      default:                    normType = MT_UC;
    endcase
  endfunction

  // Merge of range result and page attribute
  function automatic logic [2:0] mergeType(input logic [2:0] rangeT,
                                           input logic [2:0] pageT);
    logic [2:0] r;
    logic [2:0] p;
    r = normType(rangeT);
    p = normType(pageT);
    if (r == MT_UC || p == MT_UC)      mergeType = MT_UC;
    else if (r == MT_WC || p == MT_WC) mergeType = MT_WC;
    else if (r == MT_WT || p == MT_WT) mergeType = MT_WT;
    else if (r == MT_WP || p == MT_WP) mergeType = MT_WP;
    else                               mergeType = MT_WB;
  endfunction

endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 5,
  localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  output mtrStrb_t          strb,
  output logic [IDX_W-1:0]  rangeIdx,
  output logic              flushReq
);

  localparam int RANGE_SLOTS = 2 * NUM_RANGES;

  logic [ADDR_W-1:0] offs;
  logic              inRange;
  logic              isCtl;
  logic              flushQ;

  always_comb begin
    offs     = cfgAddr - ADDR_W'(2);
    isCtl    = (cfgAddr == '0);
    inRange  = (cfgAddr >= ADDR_W'(2)) && (int'(offs) < RANGE_SLOTS);
    rangeIdx = IDX_W'(offs >> 1);

    strb.ctlWe   = cfgWrEn && isCtl;
    strb.rangeWe = cfgWrEn && inRange;
    strb.maskSel = offs[0];
    strb.flush   = cfgWrEn && (isCtl || inRange);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushQ <= 1'b0;
    else       flushQ <= strb.flush;
  end

  assign flushReq = flushQ;

endmodule

// File: rtl/mtr_datapath.sv
module mtr_datapath
  import mtr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int PFN_W      = 20,
  localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int DATA_W    = PFN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mtrStrb_t          strb,
  input  logic [IDX_W-1:0]  rangeIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lkReq,
  input  logic [PFN_W-1:0]  lkPfn,
  input  logic [2:0]        lkPageType,
  output logic              rspValid,
  output logic [2:0]        rspType
);

  logic [2:0] defTypeQ;
  logic       enQ;

  logic [NUM_RANGES-1:0] hit;
  logic [NUM_RANGES-1:0] hitUc, hitWc, hitWt, hitWp, hitWb;

  // Control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      defTypeQ <= MT_UC;
      enQ      <= 1'b0;
    end else if (strb.ctlWe) begin
      defTypeQ <= wrData[2:0];
      enQ      <= wrData[3];
    end
  end

  // Range bank, one slice per range
  for (genvar i = 0; i < NUM_RANGES; i++) begin : gRange
    logic [PFN_W-1:0] baseQ;
    logic [PFN_W-1:0] maskQ;
    logic [2:0]       typeQ;
    logic             validQ;
    logic             sel;
    logic [2:0]       nt;

    assign sel = strb.rangeWe && (rangeIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ  <= '0;
        maskQ  <= '0;
        typeQ  <= MT_UC;
        validQ <= 1'b0;
      end else if (sel) begin
        if (strb.maskSel) begin
          maskQ  <= wrData[DATA_W-1:3];
          validQ <= wrData[0];
        end else begin
          baseQ  <= wrData[DATA_W-1:3];
          typeQ  <= wrData[2:0];
        end
      end
    end

    assign nt     = normType(typeQ);
    assign hit[i] = validQ && ((lkPfn & maskQ) == (baseQ & maskQ));
    assign hitUc[i] = hit[i] && (nt == MT_UC);
    assign hitWc[i] = hit[i] && (nt == MT_WC);
    assign hitWt[i] = hit[i] && (nt == MT_WT);
    assign hitWp[i] = hit[i] && (nt == MT_WP);
    assign hitWb[i] = hit[i] && (nt == MT_WB);
  end

  // Overlap resolution
  logic       anyWc, anyWt, anyWp, anyWb;
  logic [2:0] kinds;
  logic [2:0] rangeType;

  always_comb begin
    anyWc = |hitWc;
    anyWt = |hitWt;
    anyWp = |hitWp;
    anyWb = |hitWb;
    kinds = 3'(anyWc) + 3'(anyWt) + 3'(anyWp) + 3'(anyWb);

    if (!enQ)                         rangeType = MT_UC;
    else if (hit == '0)               rangeType = normType(defTypeQ);
    else if (|hitUc)                  rangeType = MT_UC;
    else if (kinds == 3'd1) begin
      if (anyWc)                      rangeType = MT_WC;
      else if (anyWt)                 rangeType = MT_WT;
      else if (anyWp)                 rangeType = MT_WP;
      else                            rangeType = MT_WB;
    end
    else if (kinds == 3'd2 && anyWt && anyWb) rangeType = MT_WT;
    else                              rangeType = MT_UC;
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspType  <= MT_UC;
    end else begin
      rspValid <= lkReq;
      if (lkReq) rspType <= mergeType(rangeType, lkPageType);
    end
  end

endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
  import mtr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int PFN_W      = 20,
  parameter int ADDR_W     = $clog2(2 * NUM_RANGES + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [PFN_W+2:0]  cfgWrData,
  input  logic              lkReq,
  input  logic [PFN_W-1:0]  lkPfn,
  input  logic [2:0]        lkPageType,
  output logic              rspValid,
  output logic [2:0]        rspType,
  output logic              flushReq
);

  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

  mtrStrb_t         strb;
  logic [IDX_W-1:0] rangeIdx;

  mtr_ctrl #(
    .NUM_RANGES(NUM_RANGES),
    .ADDR_W    (ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .strb    (strb),
    .rangeIdx(rangeIdx),
    .flushReq(flushReq)
  );

  mtr_datapath #(
    .NUM_RANGES(NUM_RANGES),
    .PFN_W     (PFN_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rangeIdx  (rangeIdx),
    .wrData    (cfgWrData),
    .lkReq     (lkReq),
    .lkPfn     (lkPfn),
    .lkPageType(lkPageType),
    .rspValid  (rspValid),
    .rspType   (rspType)
  );

endmodule

// File: rtl/mem_type_resolver_chk.sv
module mem_type_resolver_chk
  import mtr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic              lkReq,
  input logic [2:0]        lkPageType,
  input logic              rspValid,
  input logic [2:0]        rspType,
  input logic              flushReq
);

  logic mappedWr;
  assign mappedWr = cfgWrEn &&
                    ((int'(cfgAddr) == 0) ||
                     (int'(cfgAddr) >= 2 && int'(cfgAddr) < 2 * NUM_RANGES + 2));

  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> rspValid);

  assert_no_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |=> !rspValid);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspType == MT_UC || rspType == MT_WC || rspType == MT_WT ||
                  rspType == MT_WP || rspType == MT_WB));

  assert_page_uc_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && normType(lkPageType) == MT_UC) |=> (rspType == MT_UC));

  assert_page_wc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && lkPageType == MT_WC) |=> (rspType == MT_UC || rspType == MT_WC));

  assert_flush_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    mappedWr |=> flushReq);

  assert_no_spurious_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    !mappedWr |=> !flushReq);

endmodule

bind mem_type_resolver mem_type_resolver_chk #(
  .NUM_RANGES(NUM_RANGES),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .lkReq     (lkReq),
  .lkPageType(lkPageType),
  .rspValid  (rspValid),
  .rspType   (rspType),
  .flushReq  (flushReq)
);

// File: tb/mem_type_resolver_tb_top.sv
`timescale 1ns/1ps
module mem_type_resolver_tb_top;

  localparam int N      = 8;
  localparam int PW     = 20;
  localparam int AW     = $clog2(2 * N + 2);
  localparam int NPROBE = 19;

  localparam logic [2:0] UC = 3'd0, WC = 3'd1, WT = 3'd4, WP = 3'd5, WB = 3'd6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [PW+2:0] cfgWrData = '0;
  logic          lkReq = 1'b0;
  logic [PW-1:0] lkPfn = '0;
  logic [2:0]    lkPageType = 3'd0;
  logic          rspValid;
  logic [2:0]    rspType;
  logic          flushReq;

  int total = 0;
  int bad   = 0;

  // Shadow state for the reference model
  logic [PW-1:0] sBase [N];
  logic [PW-1:0] sMask [N];
  logic [2:0]    sType [N];
  logic          sValid[N];
  logic [2:0]    sDef;
  logic          sEn;

  logic [PW-1:0] probes[NPROBE] = '{
    20'h000FF, 20'h00100, 20'h0017F, 20'h00180, 20'h0018F, 20'h00190,
    20'h0019F, 20'h001C0, 20'h001FF, 20'h00200, 20'h0027F, 20'h00280,
    20'h002FF, 20'h00300, 20'h003FF, 20'h00400, 20'h00401, 20'h00500,
    20'hFFFFF };

  always #10 clk = ~clk;  // 50 MHz

  mem_type_resolver #(.NUM_RANGES(N), .PFN_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .lkReq(lkReq), .lkPfn(lkPfn),
    .lkPageType(lkPageType), .rspValid(rspValid), .rspType(rspType),
    .flushReq(flushReq));

  function automatic logic [2:0] fold(input logic [2:0] t);
    return (t == WC || t == WT || t == WP || t == WB) ? t : UC;
  endfunction

  function automatic logic [2:0] refRange(input logic [PW-1:0] pfn);
    logic any, u, c, t, p, b;
    int   n;
    if (!sEn) return UC;
    any = 0; u = 0; c = 0; t = 0; p = 0; b = 0;
    for (int i = 0; i < N; i++) begin
      if (sValid[i] && ((pfn & sMask[i]) == (sBase[i] & sMask[i]))) begin
        any = 1;
        case (fold(sType[i]))
          WC: c = 1; WT: t = 1; WP: p = 1; WB: b = 1; default: u = 1;
        endcase
      end
    end
    if (!any) return fold(sDef);
    if (u) return UC;
    n = int'(c) + int'(t) + int'(p) + int'(b);
    if (n == 1) return c ? WC : t ? WT : p ? WP : WB;
    if (n == 2 && t && b) return WT;
    return UC;
  endfunction

  function automatic logic [2:0] refEff(input logic [PW-1:0] pfn, input logic [2:0] pg);
    logic [2:0] r, q;
    r = refRange(pfn);
    q = fold(pg);
    if (r == UC || q == UC) return UC;
    if (r == WC || q == WC) return WC;
    if (r == WT || q == WT) return WT;
    if (r == WP || q == WP) return WP;
    return WB;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doLookup(input logic [PW-1:0] pfn, input logic [2:0] pg, input string req);
    logic [2:0] e;
    e = refEff(pfn, pg);
    @(negedge clk);
    lkReq = 1'b1; lkPfn = pfn; lkPageType = pg;
    @(negedge clk);
    lkReq = 1'b0;
    check(rspValid == 1'b1, "R8", int'(rspValid), 1);
    check(rspType == e, req, int'(rspType), int'(e));
  endtask

  task automatic doWrite(input int addr, input logic [PW+2:0] data);
    logic mapped;
    mapped = (addr == 0) || (addr >= 2 && addr < 2 * N + 2);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = AW'(addr); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(flushReq == mapped, "R9", int'(flushReq), int'(mapped));
    if (mapped) begin
      if (addr == 0) begin
        sDef = data[2:0]; sEn = data[3];
      end else if (addr % 2 == 0) begin
        sBase[(addr - 2) / 2] = data[PW+2:3]; sType[(addr - 2) / 2] = data[2:0];
      end else begin
        sMask[(addr - 2) / 2] = data[PW+2:3]; sValid[(addr - 2) / 2] = data[0];
      end
    end
    @(negedge clk);
    check(flushReq == 1'b0, "R9", int'(flushReq), 0);
  endtask

  task automatic setRange(input int i, input logic [PW-1:0] base, input logic [2:0] t,
                          input logic [PW-1:0] mask, input logic v);
    doWrite(2 + 2 * i, {base, t});
    doWrite(3 + 2 * i, {mask, 2'b00, v});
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < NPROBE; k++)
      for (int pg = 0; pg < 8; pg++)
        doLookup(probes[k], 3'(pg), req);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      sBase[i] = '0; sMask[i] = '0; sType[i] = UC; sValid[i] = 1'b0;
    end
    sDef = UC; sEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 1'b0, "R1", int'(rspValid), 0);
    check(flushReq == 1'b0, "R1", int'(flushReq), 0);
    for (int pg = 0; pg < 8; pg++) doLookup(20'h00100, 3'(pg), "R1");
    // R8: no request, no response
    @(negedge clk);
    check(rspValid == 1'b0, "R8", int'(rspValid), 0);

    // R6: enabled, nothing mapped, fallback WB
    doWrite(0, {{(PW-1){1'b0}}, 4'b1000 | {1'b0, WB}});
    sweep("R6");
    // R7: fallback type varied against all page types
    for (int d = 0; d < 8; d++) begin
      doWrite(0, (PW+3)'({1'b1, 3'(d)}));
      for (int pg = 0; pg < 8; pg++) doLookup(20'h00042, 3'(pg), "R7");
    end

    // R4, R5: overlapping ranges
    doWrite(0, (PW+3)'({1'b1, WB}));
    setRange(0, 20'h00100, WB, 20'hFFF00, 1'b1);
    setRange(1, 20'h00180, WT, 20'hFFFC0, 1'b1);
    setRange(2, 20'h00190, UC, 20'hFFFF0, 1'b1);
    setRange(3, 20'h00200, WC, 20'hFFF00, 1'b1);
    setRange(4, 20'h00200, WP, 20'hFFF80, 1'b1);
    setRange(5, 20'h00300, 3'd2, 20'hFFF00, 1'b1);
    setRange(6, 20'h00400, WP, 20'hFFFFF, 1'b1);
    setRange(7, 20'h00500, WC, 20'hFFFFF, 1'b0);
    sweep("R5");
    // R4: same-type overlap and invalid range ignored
    setRange(7, 20'h00400, WP, 20'hFFFF0, 1'b1);
    sweep("R4");
    setRange(7, 20'h00400, WP, 20'hFFFF0, 1'b0);

    // R9 / R3: unmapped writes change nothing
    doWrite(1, '1);
    doWrite(2 * N + 2, '1);
    doWrite((1 << AW) - 1, '1);
    sweep("R3");

    // R2: reserved fallback folds to UC
    doWrite(0, (PW+3)'({1'b1, 3'd7}));
    for (int pg = 0; pg < 8; pg++) doLookup(20'h000FF, 3'(pg), "R2");

    // R6: disable forces UC regardless of ranges
    doWrite(0, (PW+3)'({1'b0, WB}));
    sweep("R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule